// File: doc/BRIEF.md
# Clock Synchronizer Mode Controller

This block is the control state machine for one digital PLL channel of a jitter-attenuating clock generator. It watches a set of per-input clock-valid flags, a configuration mask that says which inputs the channel may use, and a lock indication from the loop. From these it decides whether the channel is initializing, free-running on its local reference, acquiring lock, locked, or holding over on stored history. It also chooses the input clock the loop should follow.

Two of its outputs steer the loop. The input index selects the reference the phase detector uses. The bandwidth select requests the wide fast-lock setting while the loop pulls in, and the normal setting at all other times. An active-low loss-of-lock pin and an active-high lock status bit report the lock state.

When the followed input disappears, the controller first tries to move to another usable input. It falls back to holdover only when no other input is usable and the history is trustworthy. Otherwise it falls back to free-run. The phase detector, loop filter, oscillator and frequency qualification all live outside the block.

Top module: `sync_mode_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the outputs become mode 0 (init), sel_idx 0, lol_n 0, lock_stat 0 and bw_fast 0.
- R2: In init mode (code 0) the controller stays in init until init_done is seen high at a clock edge, and then enters free-run (code 1) on that edge.
- R3: In free-run (code 1) the controller stays put while no input is usable. An input is usable when both its in_valid bit and its in_enable bit are 1. When any input is usable, the controller enters lock acquisition (code 2) on the next edge.
- R4: Whenever the controller picks a new input, it picks the usable input with the lowest index. An input whose in_enable bit is 0 is never picked, even if it is valid.
- R5: In acquisition (code 2), if the followed input stays usable and lock_ok is high, the next mode is locked (code 3). If lock_ok is low, the mode stays at 2.
- R6: bw_fast is 1 exactly when the mode is acquisition and fastlock_en was 1 at the edge that produced that mode.
- R7: In acquisition or locked mode, if the followed input is no longer usable and another input is usable, the controller re-enters acquisition on the lowest-index usable input.
- R8: In acquisition or locked mode, if the followed input is no longer usable and no input is usable, the next mode is holdover (code 4) when hist_valid is 1. Otherwise the next mode is free-run (code 1).
- R9: In holdover (code 4) the controller enters acquisition as soon as any input is usable. Otherwise it stays in holdover.
- R10: lol_n and lock_stat are 1 exactly when the mode is locked (code 3), and 0 in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_done | input | 1 | Channel initialization complete |
| in_valid | input | N_IN | Per-input clock qualified flags |
| in_enable | input | N_IN | Per-input usage mask |
| lock_ok | input | 1 | Loop reports phase lock on followed input |
| fastlock_en | input | 1 | Use wide bandwidth during acquisition |
| hist_valid | input | 1 | Holdover history is trustworthy |
| mode | output | 3 | 0 init, 1 free-run, 2 acquire, 3 locked, 4 holdover |
| sel_idx | output | IDX_W | Index of followed input |
| bw_fast | output | 1 | 1 = fast-lock bandwidth, 0 = normal |
| lol_n | output | 1 | Active-low loss-of-lock |
| lock_stat | output | 1 | Lock achieved status |

## Verification
The hardest case to reach is a failure of the followed input while the channel is in acquisition or locked mode, with the set of other usable inputs and hist_valid chosen on purpose. The sequence that reaches it must first win lock and then drop one specific input, leaving exactly zero or several others usable. Directed sequences build each variant. These are: failover to a higher index, a masked-but-valid input that must be skipped, holdover with history, and free-run without it. Long random runs then use slowly toggling valid flags to produce many more failures mid-acquisition and mid-lock.

// File: rtl/sync_mode_pkg.sv
// Shared types for the clock synchronizer mode controller.
// Assumes: mode codes are visible at the top-level port and must not be renumbered.
package sync_mode_pkg;
    typedef enum logic [2:0] {
        MODE_INIT = 3'd0,
        MODE_FREE = 3'd1,
        MODE_ACQ  = 3'd2,
        MODE_LOCK = 3'd3,
        MODE_HOLD = 3'd4
    } sm_mode_t;
endpackage

// File: rtl/sync_in_pick.sv
// Priority picker: finds the lowest-index usable input.
// Assumes: usable vector already combines valid and enable flags.
module sync_in_pick #(
    parameter int N_IN  = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_IN-1:0]  usable,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest set bit wins last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (usable[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/sync_sel_watch.sv
// Watches the currently followed input and reports whether it is still usable.
// Assumes: sel values past N_IN-1 count as not usable.
module sync_sel_watch #(
    parameter int N_IN  = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_IN-1:0]  usable,
    input  logic [IDX_W-1:0] sel,
    output logic             sel_ok
);
    logic [N_IN-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < N_IN; g++) begin : g_hit
            // One match term per input position.
            assign hit[g] = usable[g] && (sel == IDX_W'(g));
        end
    endgenerate

    // Any matching usable position means the followed input is healthy.
    assign sel_ok = |hit;
endmodule

// File: rtl/sync_mode_fsm.sv
// Mode state machine: init, free-run, acquire, locked, holdover, with input failover.
// Assumes: pick_found/pick_idx and sel_ok are combinational views of the same cycle's inputs.
module sync_mode_fsm
    import sync_mode_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_done,
    input  logic             lock_ok,
    input  logic             fastlock_en,
    input  logic             hist_valid,
    input  logic             pick_found,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             sel_ok,
    output sm_mode_t         mode_q,
    output logic [IDX_W-1:0] sel_q,
    output logic             bw_fast_q,
    output logic             locked_q
);
    sm_mode_t         mode_d;
    logic [IDX_W-1:0] sel_d;

    // Next-state and next-selection decision.
    always_comb begin
        mode_d = mode_q;
        sel_d  = sel_q;
        unique case (mode_q)
            MODE_INIT: begin
                if (init_done) mode_d = MODE_FREE;
            end
            MODE_FREE, MODE_HOLD: begin
                if (pick_found) begin
                    mode_d = MODE_ACQ;
                    sel_d  = pick_idx;
                end
            end
            MODE_ACQ, MODE_LOCK: begin
                if (!sel_ok) begin
                    if (pick_found) begin
                        mode_d = MODE_ACQ;
                        sel_d  = pick_idx;
                    end else if (hist_valid) begin
                        mode_d = MODE_HOLD;
                    end else begin
                        mode_d = MODE_FREE;
                    end
                end else if (mode_q == MODE_ACQ && lock_ok) begin
                    mode_d = MODE_LOCK;
                end
            end
            default: mode_d = MODE_INIT;
        endcase
    end

    // State, selection and registered status outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_INIT;
            sel_q     <= '0;
            bw_fast_q <= 1'b0;
            locked_q  <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            sel_q     <= sel_d;
            bw_fast_q <= (mode_d == MODE_ACQ) && fastlock_en;
            locked_q  <= (mode_d == MODE_LOCK);
        end
    end
endmodule

// File: rtl/sync_mode_ctrl.sv
// Top: operating-mode controller for one PLL channel.
// Assumes: in_valid is already qualified and synchronous to clk; lock_ok comes from the loop.
module sync_mode_ctrl
    import sync_mode_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_done,
    input  logic [N_IN-1:0]  in_valid,
    input  logic [N_IN-1:0]  in_enable,
    input  logic             lock_ok,
    input  logic             fastlock_en,
    input  logic             hist_valid,
    output logic [2:0]       mode,
    output logic [IDX_W-1:0] sel_idx,
    output logic             bw_fast,
    output logic             lol_n,
    output logic             lock_stat
);
    logic [N_IN-1:0]  usable;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic             sel_ok;
    sm_mode_t         mode_q;
    logic             locked_q;

    // An input counts only when it is both qualified and allowed.
    assign usable = in_valid & in_enable;

    sync_in_pick #(.N_IN(N_IN), .IDX_W(IDX_W)) u_pick (
        .usable (usable),
        .found  (pick_found),
        .idx    (pick_idx)
    );

    sync_sel_watch #(.N_IN(N_IN), .IDX_W(IDX_W)) u_watch (
        .usable (usable),
        .sel    (sel_idx),
        .sel_ok (sel_ok)
    );

    sync_mode_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_done   (init_done),
        .lock_ok     (lock_ok),
        .fastlock_en (fastlock_en),
        .hist_valid  (hist_valid),
        .pick_found  (pick_found),
        .pick_idx    (pick_idx),
        .sel_ok      (sel_ok),
        .mode_q      (mode_q),
        .sel_q       (sel_idx),
        .bw_fast_q   (bw_fast),
        .locked_q    (locked_q)
    );

    // Export mode code and the two lock indications.
    assign mode      = mode_q;
    assign lol_n     = locked_q;
    assign lock_stat = locked_q;
endmodule

// File: rtl/sync_mode_ctrl_chk.sv
// Checker for sync_mode_ctrl; attached by bind below.
// Assumes: mode codes 0..4 as defined in sync_mode_pkg.
module sync_mode_ctrl_chk #(
    parameter int N_IN  = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_done,
    input logic [N_IN-1:0]  in_valid,
    input logic [N_IN-1:0]  in_enable,
    input logic             lock_ok,
    input logic             hist_valid,
    input logic [2:0]       mode,
    input logic [IDX_W-1:0] sel_idx,
    input logic             bw_fast,
    input logic             lol_n,
    input logic             lock_stat
);
    logic [N_IN-1:0] q;
    logic            cur_ok;
    assign q      = in_valid & in_enable;
    assign cur_ok = (int'(sel_idx) < N_IN) ? q[sel_idx] : 1'b0;

    assert_init_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && init_done) |=> (mode == 3'd1));

    assert_lock_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && cur_ok && lock_ok) |=> (mode == 3'd3));

    assert_bw_only_acq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bw_fast |-> (mode == 3'd2));

    assert_hold_on_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'd3 || mode == 3'd2) && !cur_ok && q == '0 && hist_valid) |=> (mode == 3'd4));

    assert_hold_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && q != '0) |=> (mode == 3'd2));

    assert_lol_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lol_n == (mode == 3'd3)) && (lock_stat == lol_n));
endmodule

bind sync_mode_ctrl sync_mode_ctrl_chk #(.N_IN(N_IN), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (init_done),
    .in_valid  (in_valid),
    .in_enable (in_enable),
    .lock_ok   (lock_ok),
    .hist_valid(hist_valid),
    .mode      (mode),
    .sel_idx   (sel_idx),
    .bw_fast   (bw_fast),
    .lol_n     (lol_n),
    .lock_stat (lock_stat)
);

// File: tb/sync_mode_ctrl_test.sv
module sync_mode_ctrl_test;
    localparam int N = 4;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init_done = 1'b0;
    logic [N-1:0] in_valid = '0;
    logic [N-1:0] in_enable = '1;
    logic         lock_ok = 1'b0;
    logic         fastlock_en = 1'b0;
    logic         hist_valid = 1'b0;
    logic [2:0]   mode;
    logic [W-1:0] sel_idx;
    logic         bw_fast, lol_n, lock_stat;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int e_mode = 0;
    int e_sel = 0;
    string tag;

    always #4 clk = ~clk;

    sync_mode_ctrl #(.N_IN(N)) uut (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .in_valid(in_valid),
        .in_enable(in_enable), .lock_ok(lock_ok), .fastlock_en(fastlock_en),
        .hist_valid(hist_valid), .mode(mode), .sel_idx(sel_idx),
        .bw_fast(bw_fast), .lol_n(lol_n), .lock_stat(lock_stat)
    );

    function automatic int lowest(input logic [N-1:0] u);
        for (int i = N - 1; i >= 0; i--) if (u[i]) lowest = i;
        if (u == '0) lowest = 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model: compute next expected mode/selection from requirements.
    task automatic model_step();
        logic [N-1:0] u;
        int nm, ns;
        u  = in_valid & in_enable;
        nm = e_mode;
        ns = e_sel;
        case (e_mode)
            0: begin tag = "R2"; if (init_done) nm = 1; end
            1: begin tag = "R3"; if (u != '0) begin nm = 2; ns = lowest(u); end end
            4: begin tag = "R9"; if (u != '0) begin nm = 2; ns = lowest(u); end end
            default: begin
                if (!u[e_sel]) begin
                    if (u != '0) begin tag = "R7"; nm = 2; ns = lowest(u); end
                    else begin tag = "R8"; nm = hist_valid ? 4 : 1; end
                end else begin
                    tag = "R5";
                    if (e_mode == 2 && lock_ok) nm = 3;
                end
            end
        endcase
        e_mode = nm;
        e_sel  = ns;
    endtask

    // Drive inputs at negedge, then check outputs just after the next posedge.
    task automatic tick();
        bit fl;
        fl = fastlock_en;
        model_step();
        @(posedge clk);
        #1;
        chk(tag, int'(mode), e_mode);
        chk("R4", int'(sel_idx), e_sel);
        chk("R6", int'(bw_fast), int'(e_mode == 2 && fl));
        chk("R10", int'(lol_n), int'(e_mode == 3));
        chk("R10", int'(lock_stat), int'(e_mode == 3));
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd5347));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1", int'(mode), 0);
        chk("R1", int'(sel_idx), 0);
        chk("R1", int'(lol_n), 0);
        chk("R1", int'(lock_stat), 0);
        chk("R1", int'(bw_fast), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: stays in init until init_done
        tick(); tick();
        init_done = 1'b1; tick();

        // R3: free-run with nothing usable
        tick();
        // R4: input 0 valid but masked; 1 and 3 usable -> picks 1
        in_enable = 4'b1110; in_valid = 4'b1011; fastlock_en = 1'b1;
        tick();
        chk("R4", int'(sel_idx), 1);
        tick();
        lock_ok = 1'b1; tick();   // R5 lock
        chk("R5", int'(mode), 3);
        lock_ok = 1'b0;
        // R7: drop input 1, input 3 remains
        in_valid = 4'b1001; tick();
        chk("R7", int'(sel_idx), 3);
        // R8: everything gone with history -> holdover
        hist_valid = 1'b1; in_valid = 4'b0000; tick();
        chk("R8", int'(mode), 4);
        // R9: input 2 returns
        in_valid = 4'b0100; tick();
        chk("R9", int'(mode), 2);
        // R8: failure during acquisition, no history -> free-run
        hist_valid = 1'b0; in_valid = 4'b0000; tick();
        chk("R8", int'(mode), 1);
        in_enable = '1;

        // Random phase
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < N; i++) if ($urandom_range(15) == 0) in_valid[i] = ~in_valid[i];
            if ($urandom_range(63) == 0) in_enable = N'($urandom);
            lock_ok = ($urandom_range(3) == 0);
            if ($urandom_range(7) == 0) hist_valid = ~hist_valid;
            if ($urandom_range(31) == 0) fastlock_en = ~fastlock_en;
            tick();
        end

        // R1: reset from a running state
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1", int'(mode), 0);
        chk("R1", int'(lol_n), 0);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule